// File: doc/BRIEF.md
# Prescaled Reload Down-Timer

This block is a general-purpose 16-bit down-counter whose count rate is set by a programmable prescaler running from the system clock. A prescaler setting P yields one counter tick every 2·P+1 clock cycles. For example, P = 169 gives a 339-cycle tick, which is close to 25 µs at 13.56 MHz. Software stores a reload value one byte at a time and then issues a start. The counter takes the reload value and counts down one step per tick. When it expires, it sets a sticky interrupt-request flag.

Expiry either reloads the counter and carries on, which serves periodic time-outs and watchdogs, or stops it at zero, which serves one-shot delays. A stop command freezes the counter so that its value can be read back through two byte-wide outputs, which serves stopwatch use. In gated mode an external gate input must also be high before the prescaler and the counter can advance. A running output shows whether the timer is currently advancing.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset the count reads 0, running is 0, the interrupt flag is 0 and the stored reload value is 0.
- R2: A write strobe on reload_byte_we[0] stores wr_data into reload bits 7:0, and a strobe on reload_byte_we[1] stores it into bits 15:8. The other byte is left unchanged, and a write alone does not alter the count.
- R3: A start pulse, sampled at a clock edge, loads the count with the stored reload value from that edge on. The prescaler then begins a fresh period. While the timer is running, the count drops by one at the end of every (2·presc_val+1)-th running cycle.
- R4: A tick that finds the count at 1 or 0 is an expiry, and the interrupt flag is 1 from the following edge on.
- R5: On expiry with auto_restart=1 the count reloads and running stays 1. With auto_restart=0 the count becomes 0 and running falls to 0.
- R6: A stop pulse clears running from the next edge and holds the count at its value. Stop takes priority over a start sampled at the same edge.
- R7: With gated_mode=1, running equals the enabled state AND gate_in. While gate_in is 0, neither the count nor the prescaler phase advances.
- R8: The interrupt flag stays set until an irq_clr pulse clears it. An expiry at the same edge as irq_clr leaves the flag set.
- R9: count_hi carries count bits 15:8 and count_lo carries count bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_val | input | 12 | Prescaler setting P, giving a tick period of 2·P+1 cycles |
| reload_byte_we | input | 2 | Per-byte write strobes for the reload value (bit 1 is the high byte) |
| wr_data | input | 8 | Byte written into the reload value |
| start | input | 1 | Start pulse: load the reload value and enable counting |
| stop | input | 1 | Stop pulse: freeze the counter |
| auto_restart | input | 1 | 1 reloads on expiry, 0 stops at zero |
| gated_mode | input | 1 | 1 makes counting depend on gate_in |
| gate_in | input | 1 | External count enable, used in gated mode |
| irq_clr | input | 1 | Clears the interrupt flag |
| count_hi | output | 8 | Current count, high byte |
| count_lo | output | 8 | Current count, low byte |
| running | output | 1 | Timer enabled and allowed to count |
| irq | output | 1 | Sticky expiry flag |

## Verification
A wrong prescaler phase shows up as a count step one or more cycles early or late. It becomes visible at the first tick after start, so within 2·P+1 cycles. A wrong enable state or a wrong gate decode shows on running in the very cycle it arises. A wrong expiry decision shows one cycle later, on the interrupt flag and on the count value that follows the expiry. Because the reference model is compared with count, running and the flag on every clock, any divergence is reported at its first visible cycle and is not left to accumulate.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_STOP  = 2'd2
  } tmr_cmd_e;
endpackage

// File: rtl/tmr_reload_regs.sv
module tmr_reload_regs #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [CNT_W/tmr_pkg::BYTE_W-1:0]  byte_we,
  input  logic [tmr_pkg::BYTE_W-1:0]        wr_data,
  output logic [CNT_W-1:0]                  reload
);
  localparam int unsigned NB = CNT_W / tmr_pkg::BYTE_W;
  localparam int unsigned BW = tmr_pkg::BYTE_W;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] lane_d, lane_q;

    always_comb begin
      lane_d = lane_q;
      if (byte_we[b]) lane_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign reload[b*BW +: BW] = lane_q;
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] presc_val,
  input  logic             restart,
  input  logic             active,
  output logic             tick
);
  localparam int unsigned PH_W = PRE_W + 1;

  logic [PH_W-1:0] phase_d, phase_q;
  logic [PH_W-1:0] last_phase;

  assign last_phase = {presc_val, 1'b0};
  assign tick       = active && (phase_q == last_phase);

  always_comb begin
    phase_d = phase_q;
    if (restart)     phase_d = '0;
    else if (tick)   phase_d = '0;
    else if (active) phase_d = phase_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tmr_pkg::tmr_cmd_e  cmd,
  input  logic               tick,
  input  logic               auto_restart,
  input  logic [CNT_W-1:0]   reload,
  output logic               enabled,
  output logic [CNT_W-1:0]   count,
  output logic               expire
);
  import tmr_pkg::*;

  logic             en_d, en_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             at_end;

  assign at_end = (cnt_q <= CNT_W'(1));

  always_comb begin
    en_d   = en_q;
    cnt_d  = cnt_q;
    expire = 1'b0;
    unique case (cmd)
      CMD_STOP:  en_d = 1'b0;
      CMD_START: begin
        en_d  = 1'b1;
        cnt_d = reload;
      end
      default: begin
        if (tick) begin
          if (at_end) begin
            expire = 1'b1;
            if (auto_restart) begin
              cnt_d = reload;
            end else begin
              cnt_d = '0;
              en_d  = 1'b0;
            end
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q  <= en_d;
      cnt_q <= cnt_d;
    end
  end

  assign enabled = en_q;
  assign count   = cnt_q;
endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [PRE_W-1:0]                 presc_val,
  input  logic [CNT_W/tmr_pkg::BYTE_W-1:0] reload_byte_we,
  input  logic [tmr_pkg::BYTE_W-1:0]       wr_data,
  input  logic                             start,
  input  logic                             stop,
  input  logic                             auto_restart,
  input  logic                             gated_mode,
  input  logic                             gate_in,
  input  logic                             irq_clr,
  output logic [tmr_pkg::BYTE_W-1:0]       count_hi,
  output logic [tmr_pkg::BYTE_W-1:0]       count_lo,
  output logic                             running,
  output logic                             irq
);
  import tmr_pkg::*;

  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             enabled;
  logic             tick;
  logic             expire;
  tmr_cmd_e         cmd;
  logic             irq_d, irq_q;

  assign cmd     = stop ? CMD_STOP : (start ? CMD_START : CMD_NONE);
  assign running = enabled && (!gated_mode || gate_in);

  tmr_reload_regs #(.CNT_W(CNT_W)) u_reload (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_we (reload_byte_we),
    .wr_data (wr_data),
    .reload  (reload)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .presc_val (presc_val),
    .restart   (start),
    .active    (running),
    .tick      (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .tick         (tick),
    .auto_restart (auto_restart),
    .reload       (reload),
    .enabled      (enabled),
    .count        (count),
    .expire       (expire)
  );

  always_comb begin
    irq_d = irq_q;
    if (expire)       irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq      = irq_q;
  assign count_hi = count[CNT_W-1 -: BYTE_W];
  assign count_lo = count[BYTE_W-1:0];
endmodule

// File: rtl/prescaled_reload_timer_chk.sv
module prescaled_reload_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       stop,
  input logic       gated_mode,
  input logic       gate_in,
  input logic       irq_clr,
  input logic [7:0] count_hi,
  input logic [7:0] count_lo,
  input logic       running,
  input logic       irq
);
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable({count_hi, count_lo}));

  p_gate_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_mode && !gate_in) |-> !running);

  p_stop_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !running);

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  p_irq_from_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(running));
endmodule

bind prescaled_reload_timer prescaled_reload_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .stop       (stop),
  .gated_mode (gated_mode),
  .gate_in    (gate_in),
  .irq_clr    (irq_clr),
  .count_hi   (count_hi),
  .count_lo   (count_lo),
  .running    (running),
  .irq        (irq)
);

// File: tb/prescaled_reload_timer_tb_top.sv
`timescale 1ns/100ps
module prescaled_reload_timer_tb_top;
  logic        clk;
  logic        rst_n;
  logic [11:0] presc_val;
  logic [1:0]  reload_byte_we;
  logic [7:0]  wr_data;
  logic        start, stop, auto_restart, gated_mode, gate_in, irq_clr;
  logic [7:0]  count_hi, count_lo;
  logic        running, irq;

  int    n_checks = 0;
  int    n_bad    = 0;
  string cur_req  = "R1";
  bit    done     = 0;

  // behavioural reference state
  int m_reload, m_cnt, m_pc;
  bit m_en, m_irq;

  prescaled_reload_timer dut_i (
    .clk(clk), .rst_n(rst_n), .presc_val(presc_val),
    .reload_byte_we(reload_byte_we), .wr_data(wr_data),
    .start(start), .stop(stop), .auto_restart(auto_restart),
    .gated_mode(gated_mode), .gate_in(gate_in), .irq_clr(irq_clr),
    .count_hi(count_hi), .count_lo(count_lo), .running(running), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit m_running();
    return m_en && (!gated_mode || gate_in);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reload = 0; m_cnt = 0; m_pc = 0; m_en = 0; m_irq = 0;
    end else begin
      bit act, tk, exp_now;
      int n_cnt, n_pc, n_rel;
      bit n_en;
      act = m_running();
      tk = 0; exp_now = 0;
      n_pc = m_pc; n_cnt = m_cnt; n_en = m_en; n_rel = m_reload;
      if (act) begin
        if (m_pc == 2 * int'(presc_val)) begin tk = 1; n_pc = 0; end
        else n_pc = m_pc + 1;
      end
      if (start) n_pc = 0;
      if (stop) n_en = 0;
      else if (start) begin n_en = 1; n_cnt = m_reload; end
      else if (tk) begin
        if (m_cnt <= 1) begin
          exp_now = 1;
          if (auto_restart) n_cnt = m_reload;
          else begin n_cnt = 0; n_en = 0; end
        end else n_cnt = m_cnt - 1;
      end
      if (reload_byte_we[0]) n_rel = (n_rel & 32'hFF00) | int'(wr_data);
      if (reload_byte_we[1]) n_rel = (n_rel & 32'h00FF) | (int'(wr_data) << 8);
      if (exp_now) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      m_pc = n_pc; m_cnt = n_cnt; m_en = n_en; m_reload = n_rel;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(cur_req, "count_hi (R9)", int'(count_hi), (m_cnt >> 8) & 255);
      check(cur_req, "count_lo (R9)", int'(count_lo), m_cnt & 255);
      check(cur_req, "running", int'(running), int'(m_running()));
      check(cur_req, "irq", int'(irq), int'(m_irq));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(int lane, logic [7:0] v);
    @(negedge clk);
    reload_byte_we = 2'b00; reload_byte_we[lane] = 1'b1; wr_data = v;
    @(negedge clk);
    reload_byte_we = 2'b00;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  initial begin
    int hold;
    rst_n = 0; presc_val = 12'd1; reload_byte_we = 0; wr_data = 0;
    start = 0; stop = 0; auto_restart = 0; gated_mode = 0; gate_in = 0; irq_clr = 0;
    cyc(3);
    rst_n = 1;
    cyc(1);
    cur_req = "R1";
    check("R1", "reset count", int'({count_hi, count_lo}), 0);
    check("R1", "reset running", int'(running), 0);
    check("R1", "reset irq", int'(irq), 0);
    pulse_start();
    check("R1", "reset reload loads 0", int'({count_hi, count_lo}), 0);
    pulse_stop(); pulse_clr();

    // R2 / R9: byte writes, start loads them
    cur_req = "R2";
    write_byte(1, 8'h01);
    write_byte(0, 8'h02);
    check("R2", "write does not touch count", int'({count_hi, count_lo}), 0);
    pulse_start();
    check("R9", "count_hi after load", int'(count_hi), 8'h01);
    check("R9", "count_lo after load", int'(count_lo), 8'h02);
    write_byte(0, 8'h03);
    pulse_stop();
    pulse_start();
    check("R2", "low-byte write keeps high byte", int'({count_hi, count_lo}), 16'h0103);
    pulse_stop();

    // R3 / R4 / R5 one-shot: reload 3, P=1
    cur_req = "R3";
    write_byte(1, 8'h00);
    write_byte(0, 8'h03);
    auto_restart = 0;
    pulse_start();
    cyc(3);
    check("R3", "one step after 3 cycles", int'({count_hi, count_lo}), 2);
    cur_req = "R4";
    cyc(6);
    check("R4", "irq after expiry", int'(irq), 1);
    cur_req = "R5";
    check("R5", "one-shot stops", int'(running), 0);
    check("R5", "one-shot count zero", int'({count_hi, count_lo}), 0);
    cyc(5);

    // R8: flag clears only on request
    cur_req = "R8";
    check("R8", "irq held", int'(irq), 1);
    pulse_clr();
    check("R8", "irq cleared", int'(irq), 0);

    // R5 periodic
    cur_req = "R5";
    auto_restart = 1;
    write_byte(0, 8'h05);
    pulse_start();
    cyc(60);
    check("R5", "periodic still running", int'(running), 1);

    // R8 clear held during expiries: set wins
    cur_req = "R8";
    write_byte(0, 8'h00);
    @(negedge clk) irq_clr = 1'b1;
    cyc(20);
    @(negedge clk) irq_clr = 1'b0;
    cyc(4);

    // R6 stop freezes
    cur_req = "R6";
    write_byte(0, 8'h09);
    pulse_start();
    cyc(7);
    pulse_stop();
    hold = int'({count_hi, count_lo});
    cyc(10);
    check("R6", "frozen count", int'({count_hi, count_lo}), hold);
    check("R6", "stopped", int'(running), 0);
    @(negedge clk) begin start = 1'b1; stop = 1'b1; end
    @(negedge clk) begin start = 1'b0; stop = 1'b0; end
    check("R6", "stop beats start", int'(running), 0);
    check("R6", "stop beats start count", int'({count_hi, count_lo}), hold);

    // R7 gated
    cur_req = "R7";
    gated_mode = 1; gate_in = 0; auto_restart = 0;
    write_byte(0, 8'h06);
    pulse_start();
    check("R7", "gate low not running", int'(running), 0);
    cyc(10);
    check("R7", "gate low holds count", int'({count_hi, count_lo}), 6);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk) gate_in = ~gate_in;
      cyc(2);
    end
    gate_in = 1;
    cyc(30);
    gated_mode = 0;
    pulse_clr();

    // R3 long prescaler: P=169, reload 2 -> expiry 678 cycles after start edge
    cur_req = "R3";
    presc_val = 12'd169;
    write_byte(0, 8'h02);
    pulse_start();
    cyc(677);
    check("R3", "no irq before 2*339 cycles", int'(irq), 0);
    cyc(1);
    check("R3", "irq at 2*339 cycles", int'(irq), 1);
    cyc(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      done = 1;
      n_checks++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end
endmodule